// File: doc/BRIEF.md
# Asynchronous NAND Bus Timing Controller

This block sits between a simple request port and an 8-bit asynchronous NAND-style flash bus. Each accepted request becomes one bus access. An access has a setup phase, a strobe phase and a hold phase, followed by a turnaround gap. During the access the block drives chip enable, the read or write strobe, the command and address latch enables and the data bus. The length of each phase comes from a packed 32-bit configuration word. The word is sampled when the request is accepted, so software can prepare the next timing while an access is still running.

Two request address bits choose the kind of cycle. One marks a command cycle, which raises CLE. The other marks an address cycle, which raises ALE. With neither bit set the access is a plain data cycle. A read returns the byte seen on the bus at the end of its strobe, together with a one-cycle response pulse. An optional strobe-only chip-enable mode keeps chip enable active only while the strobe is low. An optional wait mode stretches the strobe while the device reports busy. The ready/busy pin is also brought out, registered, as bit 0 of a status byte.

Top module: `nand_bus_timer`

## Requirements
- R1: A write access drives chip enable low for its whole length, with the write strobe high for write-setup+1 cycles, then low for write-strobe+1 cycles, then high for write-hold+1 cycles. The write-setup field is cfg[29:26], write-strobe is cfg[25:20] and write-hold is cfg[19:17]. The read strobe stays high throughout.
- R2: A read access uses the same three-phase shape on the read strobe. Read-setup is cfg[16:13], read-strobe is cfg[12:7] and read-hold is cfg[6:4]. The write strobe stays high throughout.
- R3: After the hold phase come turnaround+1 cycles, with turnaround taken from cfg[3:2]. During these cycles chip enable is high, both strobes are high and req_ready is low. req_ready is high only when idle, and a request is accepted on a clock edge where req_valid and req_ready are both high.
- R4: When req_addr[1] is set, the access is a command cycle. CLE is high for every cycle in which chip enable is low, and ALE stays low. This holds even when req_addr[2] is also set.
- R5: When req_addr[2] is set and req_addr[1] is clear, the access is an address cycle with ALE high through the access and CLE low. When both bits are clear, the access is a data cycle in which neither latch enable rises. Both latch enables are low during turnaround and idle.
- R6: A read captures nand_dq_in on the last cycle of its strobe phase. rd_data shows the captured byte, and rd_valid pulses high for exactly one cycle, in the first hold cycle.
- R7: When cfg[31] is 1, chip enable is low only during the strobe phase.
- R8: When cfg[30] is 1, the strobe phase does not end while nand_rdy is low, so it lasts the longer of strobe+1 cycles and the time until the device reports ready. When cfg[30] is 0, nand_rdy has no effect on timing.
- R9: status[0] equals nand_rdy delayed by one clock, and status[7:1] are zero.
- R10: A write drives nand_dq_oe high and nand_dq_out with the request data for every cycle in which chip enable is low. A read keeps nand_dq_oe low.
- R11: During reset and after it, the block is idle: chip enable and both strobes are high, CLE, ALE, rd_valid and nand_dq_oe are low, and req_ready is high.
- R12: The configuration word is sampled at acceptance. A change of cfg during an access has no effect on that access's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg | input | 32 | Packed timing and mode word |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request may be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | bit 1 command, bit 2 address |
| req_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | One-cycle read response pulse |
| rd_data | output | 8 | Captured read byte |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_dq_out | output | 8 | Bus data out |
| nand_dq_oe | output | 1 | Bus output enable |
| nand_dq_in | input | 8 | Bus data in |
| nand_rdy | input | 1 | Ready/busy, 1 = ready |
| status | output | 8 | bit 0 registered ready |

## Verification
The bus pins change in the cycle right after the clock edge that moves the phase counter, so an access accepted at edge k shows its first setup cycle right after edge k. From then on the bench classifies one bus cycle per falling edge and counts the cycles of each phase. rd_valid and rd_data appear in the cycle after the last strobe cycle, which is the first hold cycle, and that is where the bench reads them. Because the bench changes nand_dq_in on every strobe cycle, an early or late capture returns a different byte. status[0] is due one edge after nand_rdy changes, and the bench checks it both before and after that edge.

// File: rtl/nand_bus_timer.sv
module nand_bus_timer #(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 3,
  parameter int CLE_BIT = 1,
  parameter int ALE_BIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       cfg,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              nand_ce_n,
  output logic              nand_re_n,
  output logic              nand_we_n,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic [DATA_W-1:0] nand_dq_out,
  output logic              nand_dq_oe,
  input  logic [DATA_W-1:0] nand_dq_in,
  input  logic              nand_rdy,
  output logic [7:0]        status
);
  localparam int CNT_W = 6;

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_STROBE, S_HOLD, S_TURN} phase_t;

  phase_t            state;
  logic [CNT_W-1:0]  cnt;
  logic [31:0]       cfg_q;
  logic              wr_q, cle_q, ale_q, rdy_q;
  logic [DATA_W-1:0] wdata_q;

  wire strobe_only = cfg_q[31];
  wire ext_wait    = cfg_q[30];
  wire [CNT_W-1:0] setup_len  = wr_q ? CNT_W'(cfg_q[29:26]) : CNT_W'(cfg_q[16:13]);
  wire [CNT_W-1:0] strobe_len = wr_q ? CNT_W'(cfg_q[25:20]) : CNT_W'(cfg_q[12:7]);
  wire [CNT_W-1:0] hold_len   = wr_q ? CNT_W'(cfg_q[19:17]) : CNT_W'(cfg_q[6:4]);
  wire [CNT_W-1:0] turn_len   = CNT_W'(cfg_q[3:2]);

  wire active  = (state == S_SETUP) || (state == S_STROBE) || (state == S_HOLD);
  wire in_strb = (state == S_STROBE);
  wire stall   = ext_wait && !nand_rdy;

  assign req_ready   = (state == S_IDLE);
  assign nand_ce_n   = !(active && (!strobe_only || in_strb));
  assign nand_we_n   = !(in_strb && wr_q);
  assign nand_re_n   = !(in_strb && !wr_q);
  assign nand_cle    = active && cle_q;
  assign nand_ale    = active && ale_q;
  assign nand_dq_oe  = active && wr_q;
  assign nand_dq_out = wdata_q;
  assign status      = {7'd0, rdy_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      cfg_q    <= '0;
      wr_q     <= 1'b0;
      cle_q    <= 1'b0;
      ale_q    <= 1'b0;
      wdata_q  <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
      rdy_q    <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      rdy_q    <= nand_rdy;
      unique case (state)
        S_IDLE: if (req_valid) begin
          cfg_q   <= cfg;
          wr_q    <= req_write;
          cle_q   <= req_addr[CLE_BIT];
          ale_q   <= req_addr[ALE_BIT] && !req_addr[CLE_BIT];
          wdata_q <= req_wdata;
          cnt     <= req_write ? CNT_W'(cfg[29:26]) : CNT_W'(cfg[16:13]);
          state   <= S_SETUP;
        end
        S_SETUP:
          if (cnt == '0) begin
            state <= S_STROBE;
            cnt   <= strobe_len;
          end else cnt <= cnt - 1'b1;
        S_STROBE:
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (!stall) begin
            state <= S_HOLD;
            cnt   <= hold_len;
            if (!wr_q) begin
              rd_data  <= nand_dq_in;
              rd_valid <= 1'b1;
            end
          end
        S_HOLD:
          if (cnt == '0) begin
            state <= S_TURN;
            cnt   <= turn_len;
            cle_q <= 1'b0;
            ale_q <= 1'b0;
          end else cnt <= cnt - 1'b1;
        S_TURN:
          if (cnt == '0) state <= S_IDLE;
          else cnt <= cnt - 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  logic unused_len;
  assign unused_len = |setup_len;

  p_one_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_re_n && !nand_we_n));
  p_latch_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));
  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (nand_ce_n && nand_re_n && nand_we_n && !nand_cle && !nand_ale));
  p_strobe_in_ce_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_re_n || !nand_we_n) |-> !nand_ce_n);
  p_rsp_after_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> $past(!nand_re_n) && nand_re_n);
  p_oe_not_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    nand_dq_oe |-> nand_re_n);
  p_accept_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && req_valid) |=> !req_ready);
endmodule

// File: tb/nand_bus_timer_bench.sv
module nand_bus_timer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] cfg = '0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [2:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic [7:0] nand_dq_in = '0;
  logic nand_rdy = 1'b1;
  logic req_ready, rd_valid, nand_ce_n, nand_re_n, nand_we_n, nand_cle, nand_ale, nand_dq_oe;
  logic [7:0] rd_data, nand_dq_out, status;

  int vectors = 0, errors = 0;

  always #2.5 clk = ~clk;

  nand_bus_timer u_nand_bus_timer (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .nand_ce_n(nand_ce_n), .nand_re_n(nand_re_n),
    .nand_we_n(nand_we_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in),
    .nand_rdy(nand_rdy), .status(status));

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit sm, input bit ew, input int ws, input int wst,
      input int wh, input int rs, input int rst, input int rh, input int ta);
    mk = {sm, ew, 4'(ws), 6'(wst), 3'(wh), 4'(rs), 6'(rst), 3'(rh), 2'(ta), 2'b00};
  endfunction

  int n_set, n_str, n_hold, n_gap, n_ce, ce_mis, cle_bad, ale_bad, oe_bad, dq_bad, oth_bad;
  int rsp_cnt, rsp_hold0;
  logic [7:0] rsp_byte;

  task automatic access(input bit wr, input logic [2:0] addr, input logic [7:0] wd,
      input logic [31:0] c, input bit ecle, input bit eale, input int rel,
      input logic [31:0] mid_cfg);
    bit seen_str, first;
    n_set = 0; n_str = 0; n_hold = 0; n_gap = 0; n_ce = 0; ce_mis = 0;
    cle_bad = 0; ale_bad = 0; oe_bad = 0; dq_bad = 0; oth_bad = 0; rsp_cnt = 0; rsp_hold0 = 0;
    seen_str = 0; first = 1;
    @(negedge clk);
    cfg = c; req_write = wr; req_addr = addr; req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 400 && !req_ready; i++) begin
      automatic logic sel = wr ? nand_we_n : nand_re_n;
      automatic logic oth = wr ? nand_re_n : nand_we_n;
      automatic bit act = !nand_ce_n;
      if (first) begin cfg = mid_cfg; first = 0; end
      if (!oth) oth_bad++;
      if (!nand_ce_n) n_ce++;
      if (nand_ce_n != sel) ce_mis++;
      if (rd_valid) begin
        rsp_cnt++; rsp_byte = rd_data;
        if (!sel) rsp_hold0 = -100;
        else if (n_hold == 0) rsp_hold0 = 1;
      end
      if (!sel) begin
        seen_str = 1; n_str++;
        nand_dq_in = 8'hA0 + 8'(n_str);
        if (rel != 0 && n_str == rel) nand_rdy = 1'b1;
      end else if (!seen_str) n_set++;
      else if (act) n_hold++;
      else n_gap++;
      if (c[31] == 1'b0) begin
        if (nand_cle != (ecle && act)) cle_bad++;
        if (nand_ale != (eale && act)) ale_bad++;
        if (nand_dq_oe != (wr && act)) oe_bad++;
        if (nand_dq_oe && nand_dq_out != wd) dq_bad++;
      end
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk("R11 ce_n", nand_ce_n, 1); chk("R11 re_n", nand_re_n, 1); chk("R11 we_n", nand_we_n, 1);
    chk("R11 cle/ale", nand_cle | nand_ale, 0); chk("R11 oe/rsp", nand_dq_oe | rd_valid, 0);
    chk("R11 ready", req_ready, 1);
  endtask

  task automatic t_write_cmd;
    logic [31:0] c = mk(0, 0, 2, 3, 1, 0, 0, 0, 1);
    access(1, 3'b010, 8'h5C, c, 1, 0, 0, c);
    chk("R1 setup", n_set, 3); chk("R1 strobe", n_str, 4); chk("R1 hold", n_hold, 2);
    chk("R1 re_n idle", oth_bad, 0); chk("R3 gap", n_gap, 2);
    chk("R4 cle", cle_bad, 0); chk("R4 ale", ale_bad, 0);
    chk("R10 oe", oe_bad, 0); chk("R10 data", dq_bad, 0);
  endtask

  task automatic t_addr_min;
    logic [31:0] c = mk(0, 0, 0, 0, 0, 0, 0, 0, 0);
    access(1, 3'b100, 8'h3A, c, 0, 1, 0, c);
    chk("R5 setup", n_set, 1); chk("R5 strobe", n_str, 1); chk("R5 hold", n_hold, 1);
    chk("R3 gap", n_gap, 1); chk("R5 ale", ale_bad, 0); chk("R5 cle", cle_bad, 0);
  endtask

  task automatic t_both_bits;
    logic [31:0] c = mk(0, 0, 1, 1, 1, 0, 0, 0, 0);
    access(1, 3'b110, 8'h11, c, 1, 0, 0, c);
    chk("R4 priority cle", cle_bad, 0); chk("R4 priority ale", ale_bad, 0);
  endtask

  task automatic t_read_data;
    logic [31:0] c = mk(0, 0, 0, 0, 0, 3, 5, 2, 3);
    access(0, 3'b000, 8'h00, c, 0, 0, 0, c);
    chk("R2 setup", n_set, 4); chk("R2 strobe", n_str, 6); chk("R2 hold", n_hold, 3);
    chk("R2 we_n idle", oth_bad, 0); chk("R3 gap", n_gap, 4);
    chk("R5 data no latch", cle_bad + ale_bad, 0); chk("R10 read oe", oe_bad, 0);
    chk("R6 pulses", rsp_cnt, 1); chk("R6 in first hold", rsp_hold0, 1);
    chk("R6 byte", rsp_byte, 8'hA6);
  endtask

  task automatic t_max_write;
    logic [31:0] c = mk(0, 0, 15, 63, 7, 0, 0, 0, 3);
    access(1, 3'b000, 8'hE7, c, 0, 0, 0, c);
    chk("R1 max setup", n_set, 16); chk("R1 max strobe", n_str, 64);
    chk("R1 max hold", n_hold, 8); chk("R3 max gap", n_gap, 4); chk("R10 max data", dq_bad, 0);
  endtask

  task automatic t_strobe_mode;
    logic [31:0] c = mk(1, 0, 0, 0, 0, 2, 2, 2, 0);
    access(0, 3'b000, 8'h00, c, 0, 0, 0, c);
    chk("R7 ce length", n_ce, 3); chk("R7 ce follows strobe", ce_mis, 0);
  endtask

  task automatic t_ext_wait;
    logic [31:0] c = mk(0, 1, 0, 0, 0, 0, 1, 0, 0);
    nand_rdy = 1'b0;
    access(0, 3'b000, 8'h00, c, 0, 0, 5, c);
    chk("R8 stretched", n_str, 5); chk("R8 byte", rsp_byte, 8'hA5);
    c = mk(0, 0, 0, 0, 0, 0, 1, 0, 0);
    nand_rdy = 1'b0;
    access(0, 3'b000, 8'h00, c, 0, 0, 0, c);
    chk("R8 no effect when off", n_str, 2);
    nand_rdy = 1'b1;
  endtask

  task automatic t_cfg_change;
    logic [31:0] c = mk(0, 0, 1, 2, 1, 0, 0, 0, 1);
    access(1, 3'b000, 8'h42, c, 0, 0, 0, mk(0, 0, 9, 9, 5, 0, 0, 0, 3));
    chk("R12 setup", n_set, 2); chk("R12 strobe", n_str, 3);
    chk("R12 hold", n_hold, 2); chk("R12 gap", n_gap, 2);
  endtask

  task automatic t_status;
    @(negedge clk); nand_rdy = 1'b0; #1;
    chk("R9 before edge", status[0], 1);
    @(negedge clk); chk("R9 low", status[0], 0); chk("R9 upper", status[7:1], 0);
    nand_rdy = 1'b1;
    @(negedge clk); chk("R9 high", status[0], 1);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_cmd();
    t_addr_min();
    t_both_bits();
    t_read_data();
    t_max_write();
    t_strobe_mode();
    t_ext_wait();
    t_cfg_change();
    t_status();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule